// File: doc/BRIEF.md
# Constrained Codeword Index Decoder

This block turns a binary constrained codeword back into the integer that the encoder started from. A legal codeword holds no run of the form one, then z zeros, then one, for any z from 1 up to a forbid depth y. The legal codewords of a given length are ranked in ascending binary order, and that rank is the index. The decoder reaches the rank without searching. For each set bit it adds one precomputed codebook size. Which size it adds depends on whether the bit above is also set.

The forbid depth can change on every word. Each supported depth has its own constant table of codebook sizes. A multiplexer picks which table feeds the adders, so runtime arithmetic is limited to additions. A word that carries a forbidden run, or that arrives with an unsupported depth code, is flagged as illegal and not decoded. Results appear one clock after the input strobe.

Top module: `cwdec_decoder`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge that samples `in_valid` high. It is low after any edge that samples `in_valid` low.
- R2: A clock edge that samples `rst_n` low clears `out_valid`, `out_index` and `out_illegal` to 0, even if `in_valid` is high at that edge.
- R3: For a legal word, `out_index` equals the number of legal words of the same width that are numerically smaller. Bit NBITS-1 is the most significant bit. For example, with depth 1, 8'h07 gives 6 and 8'h0E gives 10.
- R4: The all-zero word gives index 0. The all-ones word gives the codebook size minus one. For NBITS = 8 that is 113, 71 and 51 at depths 1, 2 and 3.
- R5: A word is illegal when bits i and i+z+1 are both set and all bits between them are clear, for some z with 1 ≤ z ≤ y. An illegal word sets `out_illegal` to 1 and forces `out_index` to 0.
- R6: A gap of more than y zeros between two ones is legal. For example, 8'h09 is legal at depth 1 with index 8 and illegal at depth 2.
- R7: `in_depth` holds y directly: the codes 1, 2 and 3 select depths 1, 2 and 3. Code 0 marks the word illegal, with index 0.
- R8: Back-to-back words may each carry a different depth. Each result follows its own word's depth.
- R9: While `in_valid` is low, `out_index` and `out_illegal` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe for the input word |
| in_word | input | NBITS | Codeword to decode |
| in_depth | input | 2 | Forbid depth y; code 0 is unsupported |
| out_valid | output | 1 | Strobe for the result |
| out_index | output | NBITS | Decoded index, or 0 for an illegal word |
| out_illegal | output | 1 | High when the word or the depth code is not legal |

## Verification
The bench builds the decoder with NBITS = 8. At that width all 256 words can be swept at every depth, and the independent model can rank each word by brute-force counting in reasonable time. That width also gives codebook sizes large enough that every table entry and every position of a forbidden run is used. During the sweep the depth changes on every word. Idle gaps and a reset applied with a word strobed in are mixed between the decoded words.

// File: rtl/cwdec_pkg.sv
// Shared constants and the constant function that builds the codebook-size
// tables. Assumes depths up to MAX_DEPTH and table positions up to 70.
package cwdec_pkg;

    localparam int MAX_DEPTH = 3;
    localparam int DEPTH_W   = $clog2(MAX_DEPTH + 1);

    // Number of legal words of length m at depth y (1 for m <= 0).
    function automatic longint card_count(input int m, input int y);
        longint t [0:79];
        if (m <= 0) return 64'd1;
        if (m == 1) return 64'd2;
        for (int k = 0; k <= 8; k++) t[k] = 64'd1;
        t[9] = 64'd2;
        for (int mm = 2; mm <= m; mm++) begin
            t[mm + 8] = 2 * t[mm + 7] - t[mm + 6] + t[mm + 8 - y - 2];
        end
        return t[m + 8];
    endfunction

endpackage

// File: rtl/cwdec_card_rom.sv
// Constant table for one forbid depth. For each bit position j it gives
// the size added when the bit above is clear, N(j), and when it is set,
// N(j - DEPTH). Assumes NBITS <= 62 so every value fits the table.
module cwdec_card_rom #(
    parameter int NBITS = 16,
    parameter int DEPTH = 1
) (
    output logic [NBITS-1:0] n_free  [NBITS],
    output logic [NBITS-1:0] n_after [NBITS]
);

    // One pair of constant entries per bit position.
    for (genvar j = 0; j < NBITS; j++) begin : g_pos
        localparam longint VF = cwdec_pkg::card_count(j, DEPTH);
        localparam longint VA = cwdec_pkg::card_count(j - DEPTH, DEPTH);
        assign n_free[j]  = NBITS'(VF);
        assign n_after[j] = NBITS'(VA);
    end

endmodule

// File: rtl/cwdec_card_mux.sv
// Holds one size table per supported depth and forwards the table picked
// by depth_sel. Unsupported codes fall back to the depth-1 table; the
// pattern checker flags those words anyway.
module cwdec_card_mux #(
    parameter int NBITS = 16
) (
    input  logic [cwdec_pkg::DEPTH_W-1:0] depth_sel,
    output logic [NBITS-1:0]              sel_free  [NBITS],
    output logic [NBITS-1:0]              sel_after [NBITS]
);
    import cwdec_pkg::*;

    logic [NBITS-1:0] tab_free  [MAX_DEPTH][NBITS];
    logic [NBITS-1:0] tab_after [MAX_DEPTH][NBITS];

    // One table per depth, copied into the shared arrays.
    for (genvar d = 0; d < MAX_DEPTH; d++) begin : g_depth
        logic [NBITS-1:0] rom_free  [NBITS];
        logic [NBITS-1:0] rom_after [NBITS];

        cwdec_card_rom #(.NBITS(NBITS), .DEPTH(d + 1)) u_rom (
            .n_free  (rom_free),
            .n_after (rom_after)
        );

        for (genvar j = 0; j < NBITS; j++) begin : g_copy
            assign tab_free[d][j]  = rom_free[j];
            assign tab_after[d][j] = rom_after[j];
        end
    end

    // Pick the table that matches the requested depth.
    always_comb begin
        int idx;
        idx = 0;
        for (int d = 1; d < MAX_DEPTH; d++) begin
            if (int'(depth_sel) == d + 1) idx = d;
        end
        for (int j = 0; j < NBITS; j++) begin
            sel_free[j]  = tab_free[idx][j];
            sel_after[j] = tab_after[idx][j];
        end
    end

endmodule

// File: rtl/cwdec_term_sum.sv
// Adds one table entry per set bit of the word. The entry chosen depends
// on the bit above, which is taken as 0 beyond the top bit. Assumes a
// legal word; the sum of an illegal word is discarded by the caller.
module cwdec_term_sum #(
    parameter int NBITS = 16
) (
    input  logic [NBITS-1:0] word,
    input  logic [NBITS-1:0] sel_free  [NBITS],
    input  logic [NBITS-1:0] sel_after [NBITS],
    output logic [NBITS-1:0] sum
);

    logic [NBITS:0] word_ext;

    assign word_ext = {1'b0, word};

    // Accumulate the selected sizes over all bit positions.
    always_comb begin
        logic [NBITS-1:0] acc;
        acc = '0;
        for (int j = 0; j < NBITS; j++) begin
            if (word_ext[j]) begin
                acc = acc + (word_ext[j + 1] ? sel_after[j] : sel_free[j]);
            end
        end
        sum = acc;
    end

endmodule

// File: rtl/cwdec_pattern_chk.sv
// Detects a forbidden run (one, z zeros, one) with z up to the requested
// depth. Also flags the unsupported depth code 0 and codes above
// MAX_DEPTH. Needs NBITS >= 3.
module cwdec_pattern_chk #(
    parameter int NBITS = 16
) (
    input  logic [NBITS-1:0]              word,
    input  logic [cwdec_pkg::DEPTH_W-1:0] depth_sel,
    output logic                          illegal
);
    import cwdec_pkg::*;

    logic [MAX_DEPTH-1:0] gap_hit;
    logic [MAX_DEPTH-1:0] gap_enabled;
    logic                 depth_bad;

    // One row of detectors per gap length z = g + 1.
    for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_gap
        localparam int Z = g + 1;
        logic [NBITS-1:0] row;
        for (genvar i = 0; i < NBITS; i++) begin : g_start
            if (i + Z + 1 <= NBITS - 1) begin : g_fit
                assign row[i] = word[i] & word[i + Z + 1] & ~(|word[i + Z:i + 1]);
            end else begin : g_none
                assign row[i] = 1'b0;
            end
        end
        assign gap_hit[g]     = |row;
        assign gap_enabled[g] = (int'(depth_sel) >= Z);
    end

    assign depth_bad = (depth_sel == '0) || (int'(depth_sel) > MAX_DEPTH);
    assign illegal   = depth_bad || |(gap_hit & gap_enabled);

endmodule

// File: rtl/cwdec_decoder.sv
// Top level of the codeword-to-index decoder. It has a combinational
// table lookup and adder, a pattern check, and one output register stage.
// Reset is synchronous and active low.
module cwdec_decoder #(
    parameter int NBITS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NBITS-1:0]              in_word,
    input  logic [cwdec_pkg::DEPTH_W-1:0] in_depth,
    output logic                          out_valid,
    output logic [NBITS-1:0]              out_index,
    output logic                          out_illegal
);

    logic [NBITS-1:0] sel_free  [NBITS];
    logic [NBITS-1:0] sel_after [NBITS];
    logic [NBITS-1:0] raw_sum;
    logic             word_bad;

    cwdec_card_mux #(.NBITS(NBITS)) u_mux (
        .depth_sel (in_depth),
        .sel_free  (sel_free),
        .sel_after (sel_after)
    );

    cwdec_term_sum #(.NBITS(NBITS)) u_sum (
        .word      (in_word),
        .sel_free  (sel_free),
        .sel_after (sel_after),
        .sum       (raw_sum)
    );

    cwdec_pattern_chk #(.NBITS(NBITS)) u_chk_pat (
        .word      (in_word),
        .depth_sel (in_depth),
        .illegal   (word_bad)
    );

    // Output strobe: follows in_valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads on a strobed word and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_index   <= '0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_index   <= word_bad ? '0 : raw_sum;
            out_illegal <= word_bad;
        end
    end

endmodule

// File: rtl/cwdec_decoder_chk.sv
// Property checker for cwdec_decoder, attached with bind. Needs NBITS >= 3.
module cwdec_decoder_chk #(
    parameter int NBITS = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [NBITS-1:0]              in_word,
    input logic [cwdec_pkg::DEPTH_W-1:0] in_depth,
    input logic                          out_valid,
    input logic [NBITS-1:0]              out_index,
    input logic                          out_illegal
);

    AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_index == '0 && !out_illegal)); // R2
    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_word == '0 && in_depth != '0) |=> (out_index == '0 && !out_illegal)); // R4
    AST_ILLEGAL_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_illegal) |-> out_index == '0); // R5
    AST_SHORT_GAP_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_word[2:0] == 3'b101) |=> out_illegal); // R5
    AST_DEPTH_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_depth == '0) |=> out_illegal); // R7
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(out_index) && $stable(out_illegal))); // R9

endmodule

bind cwdec_decoder cwdec_decoder_chk #(.NBITS(NBITS)) u_prop_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_depth    (in_depth),
    .out_valid   (out_valid),
    .out_index   (out_index),
    .out_illegal (out_illegal)
);

// File: tb/test_cwdec_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results from a brute-force
// model, and the monitor checks them as the results come out.
module test_cwdec_decoder;

    localparam int NB = 8;

    typedef struct {
        int    idx;
        bit    ill;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NB-1:0] in_word = '0;
    logic [1:0]    in_depth = 2'd1;
    logic          out_valid;
    logic [NB-1:0] out_index;
    logic          out_illegal;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    bit   have_last = 1'b0;
    int   last_idx = 0;
    bit   last_ill = 1'b0;

    always #10 clk = ~clk;

    cwdec_decoder #(.NBITS(NB)) i_cwdec_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .in_depth    (in_depth),
        .out_valid   (out_valid),
        .out_index   (out_index),
        .out_illegal (out_illegal)
    );

    // True when w holds one, z zeros, one with 1 <= z <= y.
    function automatic bit has_forbidden(input int w, input int y);
        for (int z = 1; z <= y; z++) begin
            for (int i = 0; i + z + 1 < NB; i++) begin
                if (w[i] && w[i + z + 1] && ((w >> (i + 1)) & ((1 << z) - 1)) == 0) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // Rank of w: the number of legal words below it.
    function automatic int rank_of(input int w, input int y);
        int cnt = 0;
        for (int v = 0; v < w; v++) if (!has_forbidden(v, y)) cnt++;
        return cnt;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one word and queue the given expected result.
    task automatic send_lit(input int w, input int d, input int idx, input bit ill, input string tag);
        exp_t e;
        @(negedge clk);
        e.idx = idx; e.ill = ill; e.tag = tag;
        sb_q.push_back(e);
        in_valid = 1'b1;
        in_word  = NB'(w);
        in_depth = 2'(d);
    endtask

    // Drive one word and queue the model's result.
    task automatic send(input int w, input int d, input string tag);
        bit ill;
        ill = (d == 0) || has_forbidden(w, d);
        send_lit(w, d, ill ? 0 : rank_of(w, d), ill, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge and checks against the queue.
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            have_last = 1'b0;
        end else if (!done) begin
            if (out_valid != (sb_q.size() != 0)) begin
                check(1'b0, "R1 valid timing", int'(out_valid), int'(sb_q.size() != 0));
            end else if (out_valid) begin
                exp_t e;
                e = sb_q.pop_front();
                check(int'(out_index) == e.idx, {e.tag, " index"}, int'(out_index), e.idx);
                check(out_illegal == e.ill, {e.tag, " illegal flag"}, int'(out_illegal), int'(e.ill));
                have_last = 1'b1;
                last_idx = int'(out_index);
                last_ill = out_illegal;
            end else if (have_last) begin
                check(int'(out_index) == last_idx && out_illegal == last_ill, "R9 hold while idle",
                      int'(out_index), last_idx);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        in_word  = '1;
        repeat (3) @(negedge clk);
        check(!out_valid && out_index == '0 && !out_illegal, "R2 reset state",
              int'(out_index) + int'(out_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3 known ranks, R6 wide gaps, R4 end points.
        send_lit(8'h07, 1, 6, 1'b0, "R3 word 07 depth 1");
        send_lit(8'h0E, 1, 10, 1'b0, "R3 word 0E depth 1");
        send_lit(8'h09, 1, 8, 1'b0, "R6 wide gap legal");
        send_lit(8'h09, 2, 0, 1'b1, "R5 gap 2 at depth 2");
        send_lit(8'hFF, 1, 113, 1'b0, "R4 all ones depth 1");
        send_lit(8'hFF, 2, 71, 1'b0, "R4 all ones depth 2");
        send_lit(8'hFF, 3, 51, 1'b0, "R4 all ones depth 3");
        send_lit(8'h00, 3, 0, 1'b0, "R4 all zeros");
        idle(2);

        // R7 unsupported depth code.
        send(8'h00, 0, "R7 depth code 0 zero word");
        send(8'h40, 0, "R7 depth code 0");
        idle(1);

        // Exhaustive sweep at fixed depths, with idle gaps (R9).
        for (int d = 1; d <= 3; d++) begin
            for (int w = 0; w < 256; w++) begin
                send(w, d, (d == 1) ? "R3 sweep depth 1" : (d == 2) ? "R3 sweep depth 2" : "R3 sweep depth 3");
                if (w % 37 == 0) idle(2);
            end
        end

        // R8 depth changes on every word.
        for (int w = 0; w < 256; w++) send(w, (w % 3) + 1, "R8 mixed depths");
        idle(2);

        // R5 run at the top bits and at the bottom bits.
        send(8'hA0, 1, "R5 top run z1");
        send(8'h11, 3, "R5 run z3");
        send(8'h11, 2, "R6 run z3 at depth 2");
        idle(2);

        // R2 reset while a word is strobed.
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_word = 8'h05;
        in_depth = 2'd1;
        @(posedge clk);
        #2;
        check(!out_valid && out_index == '0 && !out_illegal, "R2 reset with strobe",
              int'(out_valid) + int'(out_illegal), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        send(8'h1C, 2, "R3 after reset");
        idle(3);

        check(sb_q.size() == 0, "R1 all results seen", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule